// File: doc/BRIEF.md
# Parallel-Bus SAR Converter Sequencer

This block sits next to a 16-bit successive-approximation converter with a parallel data bus and performs one complete conversion for each host request. From a single `start` pulse it produces the chip-select, read/convert and high-byte-select waveforms. It waits for the converter to report completion, then reads the result. The result is read either as one 16-bit word or as two bytes on the low eight data lines. The finished word is returned with a one-cycle `done` strobe.

All converter timing is expressed in nanoseconds and turned into clock counts from a clock-frequency parameter: chip-select low and high widths, bus output delay and reset width. The reference wake-up time is a cycle-count parameter, so a simulation can shorten it. A conversion sequence is defined by counting chip-select falling edges. The read/convert level at each falling edge gives that edge its meaning. At the second edge the host's chosen power mode is passed to the converter. When the reference may be powered down, the sequencer stretches the gap after the first edge so the reference can settle. This applies after a conversion that ended in shutdown, after a timeout, and after reset. If the completion signal never falls, the sequencer flags a timeout and resynchronises the converter with a reset pulse.

Top module: `adc_par_ctrl`

## Requirements
- R1: After `rst` the sequencer holds `adc_cs_n` high with `busy` high and drives `adc_rst` high for the reset width, then goes idle with `busy` low; `adc_rst` is only ever high while `adc_cs_n` is high.
- R2: The first `adc_cs_n` falling edge of every conversion is made with `adc_rc` low.
- R3: At the second `adc_cs_n` falling edge `adc_rc` equals the `shdn_mode` value latched at `start` (1 = power reference down after conversion, 0 = keep it on).
- R4: The third `adc_cs_n` falling edge comes only after `adc_eoc` has fallen, and is made with `adc_rc` high.
- R5: The data bus is sampled no earlier than the output-delay count after `adc_cs_n` falls, and no earlier than that count after `adc_hben` changes.
- R6: With `byte_mode` = 0 the result is `adc_data[15:0]`. With `byte_mode` = 1 the low byte is read from `adc_data[7:0]` with `adc_hben` low, and the high byte is read from `adc_data[7:0]` with `adc_hben` high. The upper eight lines are then ignored.
- R7: The time from the first to the second falling edge is at least the wake count when the previous conversion ended in shutdown, timed out, or was the first after reset. Otherwise it is less than the wake count.
- R8: If `adc_eoc` does not fall within the timeout count, `timeout` goes high, no `done` is given, `adc_cs_n` stays high and a fresh `adc_rst` pulse is issued; `timeout` clears at the next accepted `start`.
- R9: `done` is a one-cycle pulse with `busy` low; `result` changes only with `done` and holds its value until the next `done`.
- R10: `adc_cs_n` is low only while `busy` is high, and `adc_hben` is high only while `adc_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, accepted while idle |
| shdn_mode | input | 1 | 1 = shutdown after conversion, 0 = standby; latched at start |
| byte_mode | input | 1 | 1 = read result as two bytes; latched at start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle strobe: `result` updated |
| timeout | output | 1 | Last conversion never signalled completion |
| result | output | 16 | Last converted word, unsigned binary |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rc | output | 1 | Converter read/convert select |
| adc_hben | output | 1 | Converter byte select: 0 low byte, 1 high byte |
| adc_rst | output | 1 | Converter reset pulse |
| adc_eoc | input | 1 | Converter end of conversion, falls when data valid |
| adc_data | input | 16 | Converter parallel data bus |

## Verification
The bench sweeps 24 conversions. Every pairing of power mode, bus width and previous power mode appears, along with two conversions whose completion never arrives. One corner case is a missed or misplaced wake gap: it would show up as a too-short first-to-second edge spacing after shutdown, or as a needless long stall after standby. Another is an early bus sample. The model presents a poison value until its output delay has passed, so sampling too soon after chip select falls or after the byte select flips shows up as a wrong byte. A sequencer that ignored the hung completion signal would never return. One that skipped the resynchronising reset would have its next conversion read as the wrong edge by the converter model.

// File: rtl/adc_par_pkg.sv
package adc_par_pkg;
  typedef enum logic [3:0] {
    ST_INIT,   // converter reset pulse, CS high
    ST_IDLE,   // waiting for start
    ST_ACQ,    // edge 1: CS low, R/C low
    ST_GAP1,   // CS high, R/C = mode, optional reference wake wait
    ST_CONV,   // edge 2: CS low, R/C = mode
    ST_WAIT,   // CS high, R/C high, waiting for EOC fall
    ST_READ,   // edge 3: CS low, low byte or full word
    ST_READH,  // CS low, high byte
    ST_CLOSE   // CS high before next cycle
  } ctl_state_e;
endpackage

// File: rtl/adc_phase_ctr.sv
module adc_phase_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt != {CW{1'b1}}) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_wake_guard.sv
module adc_wake_guard (
  input  logic clk,
  input  logic rst,
  input  logic ref_off,
  input  logic ref_on,
  output logic pending
);
  // Reference state is unknown after reset: treat as powered down.
  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b1;
    else if (ref_off) pending <= 1'b1;
    else if (ref_on) pending <= 1'b0;
  end
endmodule

// File: rtl/adc_result_cap.sv
module adc_result_cap #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_word,
  input  logic          cap_lo,
  input  logic          cap_hi,
  input  logic          publish,
  input  logic [DW-1:0] bus,
  output logic [DW-1:0] result
);
  localparam int BW = DW / 2;
  logic [DW-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold   <= '0;
      result <= '0;
    end else begin
      if (cap_word) hold <= bus;
      if (cap_lo) hold[BW-1:0] <= bus[BW-1:0];
      if (cap_hi) hold[DW-1:BW] <= bus[BW-1:0];
      if (publish) result <= hold;
    end
  end
endmodule

// File: rtl/adc_par_ctrl.sv
module adc_par_ctrl
  import adc_par_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CLK_MHZ     = 250,
  parameter int CS_LO_NS    = 40,
  parameter int CS_HI_NS    = 40,
  parameter int TDO_NS      = 48,
  parameter int RST_NS      = 40,
  parameter int WAKE_CYC    = 2500000,
  parameter int EOC_TMO_CYC = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              shdn_mode,
  input  logic              byte_mode,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic [DATA_W-1:0] result,
  output logic              adc_cs_n,
  output logic              adc_rc,
  output logic              adc_hben,
  output logic              adc_rst,
  input  logic              adc_eoc,
  input  logic [DATA_W-1:0] adc_data
);
  localparam int LO_CYC  = (CS_LO_NS * CLK_MHZ + 999) / 1000;
  localparam int HI_CYC  = (CS_HI_NS * CLK_MHZ + 999) / 1000;
  localparam int TDO_CYC = (TDO_NS * CLK_MHZ + 999) / 1000;
  localparam int RST_CYC = (RST_NS * CLK_MHZ + 999) / 1000;
  localparam int MAX_CYC = (WAKE_CYC > EOC_TMO_CYC) ? WAKE_CYC : EOC_TMO_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1) + 1;
  localparam logic [CW-1:0] LO_M1   = CW'(LO_CYC - 1);
  localparam logic [CW-1:0] HI_M1   = CW'(HI_CYC - 1);
  localparam logic [CW-1:0] TDO_M1  = CW'(TDO_CYC - 1);
  localparam logic [CW-1:0] RST_M1  = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] WAKE_M1 = CW'(WAKE_CYC - 1);
  localparam logic [CW-1:0] TMO_M1  = CW'(EOC_TMO_CYC - 1);

  ctl_state_e    state_q, state_d;
  logic [CW-1:0] elapsed;
  logic          mode_q, bytes_q, need_wake_q;
  logic          eoc_q, eoc_seen_q, eoc_fall;
  logic          wake_pending;
  logic          close_exit, tmo_hit;
  logic          cap_word, cap_lo, cap_hi;
  logic          cs_low_d, rc_d, hben_d, rst_d;

  assign eoc_fall = eoc_q & ~adc_eoc;

  adc_phase_ctr #(.CW(CW)) u_phase (
    .clk (clk),
    .rst (rst),
    .clr (state_d != state_q),
    .cnt (elapsed)
  );

  always_comb begin
    state_d    = state_q;
    close_exit = 1'b0;
    tmo_hit    = 1'b0;
    cap_word   = 1'b0;
    cap_lo     = 1'b0;
    cap_hi     = 1'b0;
    unique case (state_q)
      ST_INIT:  if (elapsed >= RST_M1) state_d = ST_IDLE;
      ST_IDLE:  if (start) state_d = ST_ACQ;
      ST_ACQ:   if (elapsed >= LO_M1) state_d = ST_GAP1;
      ST_GAP1:  if (elapsed >= (need_wake_q ? WAKE_M1 : HI_M1)) state_d = ST_CONV;
      ST_CONV:  if (elapsed >= LO_M1) state_d = ST_WAIT;
      ST_WAIT: begin
        if (eoc_seen_q && elapsed >= HI_M1) state_d = ST_READ;
        else if (elapsed >= TMO_M1) begin
          tmo_hit = 1'b1;
          state_d = ST_INIT;
        end
      end
      ST_READ: if (elapsed >= TDO_M1) begin
        cap_word = ~bytes_q;
        cap_lo   = bytes_q;
        state_d  = bytes_q ? ST_READH : ST_CLOSE;
      end
      ST_READH: if (elapsed >= TDO_M1) begin
        cap_hi  = 1'b1;
        state_d = ST_CLOSE;
      end
      ST_CLOSE: if (elapsed >= HI_M1) begin
        close_exit = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_INIT;
    endcase
  end

  // Pin levels for the state being entered; registered below.
  always_comb begin
    cs_low_d = 1'b0;
    rc_d     = 1'b0;
    hben_d   = 1'b0;
    rst_d    = 1'b0;
    unique case (state_d)
      ST_INIT:  rst_d = 1'b1;
      ST_ACQ:   cs_low_d = 1'b1;
      ST_GAP1:  rc_d = mode_q;
      ST_CONV:  begin cs_low_d = 1'b1; rc_d = mode_q; end
      ST_WAIT:  rc_d = 1'b1;
      ST_READ:  begin cs_low_d = 1'b1; rc_d = 1'b1; end
      ST_READH: begin cs_low_d = 1'b1; rc_d = 1'b1; hben_d = 1'b1; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_INIT;
      mode_q      <= 1'b0;
      bytes_q     <= 1'b0;
      need_wake_q <= 1'b1;
      eoc_q       <= 1'b0;
      eoc_seen_q  <= 1'b0;
      busy        <= 1'b1;
      done        <= 1'b0;
      timeout     <= 1'b0;
      adc_cs_n    <= 1'b1;
      adc_rc      <= 1'b0;
      adc_hben    <= 1'b0;
      adc_rst     <= 1'b1;
    end else begin
      state_q <= state_d;
      eoc_q   <= adc_eoc;
      if (state_q == ST_IDLE && start) begin
        mode_q      <= shdn_mode;
        bytes_q     <= byte_mode;
        need_wake_q <= wake_pending;
        timeout     <= 1'b0;
      end
      if (state_q == ST_IDLE) eoc_seen_q <= 1'b0;
      else if ((state_q == ST_CONV || state_q == ST_WAIT) && eoc_fall) eoc_seen_q <= 1'b1;
      if (tmo_hit) timeout <= 1'b1;
      busy     <= (state_d != ST_IDLE);
      done     <= close_exit;
      adc_cs_n <= ~cs_low_d;
      adc_rc   <= rc_d;
      adc_hben <= hben_d;
      adc_rst  <= rst_d;
    end
  end

  adc_wake_guard u_wake (
    .clk     (clk),
    .rst     (rst),
    .ref_off (tmo_hit | (close_exit & mode_q)),
    .ref_on  (close_exit & ~mode_q),
    .pending (wake_pending)
  );

  adc_result_cap #(.DW(DATA_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .cap_word (cap_word),
    .cap_lo   (cap_lo),
    .cap_hi   (cap_hi),
    .publish  (close_exit),
    .bus      (adc_data),
    .result   (result)
  );
endmodule

// File: rtl/adc_par_ctrl_chk.sv
module adc_par_ctrl_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              timeout,
  input logic [DATA_W-1:0] result,
  input logic              adc_cs_n,
  input logic              adc_hben,
  input logic              adc_rst
);
  assert_reset_cs_high_R1: assert property (@(posedge clk) disable iff (rst)
    adc_rst |-> adc_cs_n);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  assert_cs_in_busy_R10: assert property (@(posedge clk) disable iff (rst)
    !adc_cs_n |-> busy);

  assert_hben_in_cs_R10: assert property (@(posedge clk) disable iff (rst)
    adc_hben |-> !adc_cs_n);

  assert_tmo_no_done_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> !done);
endmodule

bind adc_par_ctrl adc_par_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .timeout  (timeout),
  .result   (result),
  .adc_cs_n (adc_cs_n),
  .adc_hben (adc_hben),
  .adc_rst  (adc_rst)
);

// File: tb/adc_par_ctrl_tb.sv
`timescale 1ns/1ps
module adc_par_ctrl_tb;
  localparam int WAKE = 300;
  localparam int TMO  = 400;
  localparam int CONV = 50;
  localparam int MDLY = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, shdn_mode = 1'b0, byte_mode = 1'b0;
  logic busy, done, timeout, adc_cs_n, adc_rc, adc_hben, adc_rst;
  logic [15:0] result, adc_data;
  logic adc_eoc = 1'b0;

  always #2 clk = ~clk;

  adc_par_ctrl #(.WAKE_CYC(WAKE), .EOC_TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst(rst), .start(start), .shdn_mode(shdn_mode), .byte_mode(byte_mode),
    .busy(busy), .done(done), .timeout(timeout), .result(result),
    .adc_cs_n(adc_cs_n), .adc_rc(adc_rc), .adc_hben(adc_hben), .adc_rst(adc_rst),
    .adc_eoc(adc_eoc), .adc_data(adc_data)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  logic [15:0] mdl_word = 16'h0;
  logic        mdl_bytes = 1'b0, mdl_hang = 1'b0, exp_mode = 1'b0, prev_shdn = 1'b1;
  logic        cs_q = 1'b1, hb_q = 1'b0, eoc_fell = 1'b0, rst_q = 1'b0;
  int          ecount = 0, t_e1 = 0, eoc_t = 0, vcnt = 0, rst_pulses = 0;
  logic        rising_after3 = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    cs_q <= adc_cs_n;
    hb_q <= adc_hben;
    rst_q <= adc_rst;
    if (adc_rst && !rst_q) rst_pulses <= rst_pulses + 1;
    if (adc_cs_n || (cs_q && !adc_cs_n) || (hb_q != adc_hben)) vcnt <= 0;
    else if (vcnt < 1000) vcnt <= vcnt + 1;
    if (adc_rst) begin
      chk(adc_cs_n, "R1 reset with CS high", adc_cs_n, 1);
      ecount <= 0;
      adc_eoc <= 1'b0;
    end else if (cs_q && !adc_cs_n) begin
      if (ecount == 0) begin
        chk(!adc_rc, "R2 rc at edge1", adc_rc, 0);
        t_e1 <= cyc;
        adc_eoc <= 1'b0;
        ecount <= 1;
      end else if (ecount == 1) begin
        chk(adc_rc == exp_mode, "R3 rc at edge2", adc_rc, exp_mode);
        if (prev_shdn) chk(cyc - t_e1 >= WAKE, "R7 wake gap", cyc - t_e1, WAKE);
        else chk(cyc - t_e1 < WAKE, "R7 no wake gap", cyc - t_e1, WAKE);
        adc_eoc <= 1'b1;
        eoc_fell <= 1'b0;
        eoc_t <= cyc;
        ecount <= 2;
      end else begin
        chk(adc_rc && eoc_fell, "R4 edge3 after eoc, rc high", {adc_rc, eoc_fell}, 3);
        ecount <= 3;
      end
    end else begin
      if (ecount == 2 && adc_eoc && !mdl_hang && cyc - eoc_t >= CONV) begin
        adc_eoc <= 1'b0;
        eoc_fell <= 1'b1;
      end
      if (ecount == 3 && !cs_q && adc_cs_n) ecount <= 0;
    end
  end

  always_comb begin
    if (adc_cs_n || vcnt < MDLY) adc_data = 16'hDEAD;
    else if (!mdl_bytes) adc_data = mdl_word;
    else adc_data = {8'hA5, adc_hben ? mdl_word[15:8] : mdl_word[7:0]};
  end

  // ---------------- stimulus ----------------
  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    summary();
  end

  task automatic run(input logic [15:0] w, input bit md, input bit bm, input bit hang,
                     input logic [15:0] last);
    int n;
    int rp;
    rp = rst_pulses;
    chk(result == last, "R9 result held until done", result, last);
    mdl_word = w; mdl_bytes = bm; mdl_hang = hang; exp_mode = md;
    shdn_mode = md; byte_mode = bm; start = 1'b1;
    @(negedge clk);
    start = 1'b0; shdn_mode = ~md; byte_mode = ~bm;
    n = 0;
    while (!done && !timeout && n < 5000) begin @(negedge clk); n++; end
    if (hang) begin
      chk(timeout && !done && adc_cs_n, "R8 timeout flagged", {timeout, done, adc_cs_n}, 5);
      while (busy && n < 5000) begin @(negedge clk); n++; end
      chk(rst_pulses == rp + 1, "R8 resync reset pulse", rst_pulses - rp, 1);
      chk(result == last, "R8 result untouched", result, last);
      prev_shdn = 1'b1;
    end else begin
      chk(done && !busy, "R9 done with busy low", {done, busy}, 2);
      chk(result == w, bm ? "R6 R5 byte result" : "R6 R5 word result", result, w);
      chk(!timeout, "R8 no timeout", timeout, 0);
      @(negedge clk);
      chk(!done, "R9 done single cycle", done, 0);
      prev_shdn = md;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [15:0] last;
    repeat (3) @(negedge clk);
    chk(adc_cs_n && busy && adc_rst, "R1 reset state", {adc_cs_n, busy, adc_rst}, 7);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    chk(!busy && adc_cs_n && !adc_rst && rst_pulses == 1, "R1 idle after reset pulse",
        {busy, adc_cs_n, adc_rst}, 2);
    chk(result == 16'h0 && !timeout, "R1 reset outputs", result, 0);
    last = 16'h0;
    for (int i = 0; i < 24; i++) begin
      logic [15:0] w;
      bit hang;
      w = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF :
          16'((i * 16'h3A7D) ^ (i << 11) ^ 16'h00FF);
      hang = (i == 10) || (i == 17);
      run(w, i[1], i[0], hang, last);
      if (!hang) last = w;
    end
    summary();
  end
endmodule